// File: doc/BRIEF.md
# PWM Time-Base Counter

This block produces the shared time base for a two-channel PWM generator. A two-stage prescaler turns the input clock into a counting tick. On each tick a 16-bit counter moves according to a selectable mode: it counts up, counts down, counts up and then down, or holds still. The counter value goes to downstream compare and action logic, together with one-cycle event strobes that mark the ticks on which the counter sits at zero or at the active period.

Software changes the configuration through register-style write strobes. One strobe loads the control fields: counter mode, period load policy, and the two prescaler fields. A second strobe loads the period. Both channels use the same period. A period write can land in a shadow copy, which is copied to the active period on the next zero event. It can also go straight into the active period. Counting and prescaling advance only while the tick-clock enable is high.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter, the active period, the shadow period and the prescaler are zero. The mode is up-count, the prescale ratio is 1, period writes go to the shadow copy, and both strobes are low while the tick enable is low.
- R2: A tick occurs once every N enabled clocks, where N = 2^ckd × (hsp == 0 ? 1 : 2×hsp), with ckd and hsp the two 3-bit prescaler fields. The largest ratio is 1792.
- R3: With mode field 2'b00 (up), each tick moves the counter from c to c+1 while c is below the active period P, and to 0 once c ≥ P.
- R4: With mode field 2'b01 (down), each tick moves the counter from c to c−1 while c > 0, and from 0 to P.
- R5: With mode field 2'b10 (up-down), the counter climbs to P, turns and descends to 0, then turns again. With P = 0 it stays at 0. Its direction is kept across other modes.
- R6: With mode field 2'b11 (freeze), the counter and its direction hold and no strobe fires.
- R7: zero_o goes high for exactly one clock, on a tick where the counter equals 0. prd_match_o does the same on a tick where the counter equals the active period. Neither fires outside a tick.
- R8: With the load-immediate bit 0, a period write changes only the shadow copy. The active period takes the shadow value on the clock where zero_o is high.
- R9: With the load-immediate bit 1, a period write shows on act_prd_o from the next clock.
- R10: While tick_en_i is low the prescaler and counter hold and no strobe fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Tick-clock enable |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_mode_i | input | 2 | Counter mode: 00 up, 01 down, 10 up-down, 11 freeze |
| ctrl_prd_imm_i | input | 1 | 1 writes the period directly into the active copy |
| ctrl_hsp_i | input | 3 | Prescaler stage 1 field (factor 1 or 2×value) |
| ctrl_ckd_i | input | 3 | Prescaler stage 2 field (factor 2^value) |
| prd_we_i | input | 1 | Period write strobe |
| prd_wdata_i | input | 16 | Period write data |
| cnt_o | output | 16 | Counter value |
| act_prd_o | output | 16 | Active period |
| zero_o | output | 1 | Counter-at-zero event strobe |
| prd_match_o | output | 1 | Counter-at-period event strobe |

## Verification
The bench builds the block with its default 16-bit counter and 3-bit prescaler fields. It uses periods no larger than a few dozen, so wraps, turnarounds and shadow loads come round within tens of ticks. Since the prescaler fields are only 3 bits wide, all 64 divide settings can be swept, up to the 1792 ratio. A cycle-accurate arithmetic model compares every output on every clock. This covers mode switches mid-count, prescaler changes mid-interval and period writes racing zero events.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;
  typedef enum logic [1:0] {
    CM_UP   = 2'b00,
    CM_DOWN = 2'b01,
    CM_UPDN = 2'b10,
    CM_FRZ  = 2'b11
  } cnt_mode_e;
endpackage

// File: rtl/pwm_tb_prescaler.sv
module pwm_tb_prescaler #(
  parameter int DIV_W   = 3,
  localparam int RATIO_W = (1 << DIV_W) - 1 + DIV_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] hsp_i,
  input  logic [DIV_W-1:0] ckd_i,
  output logic             tick_o
);
  logic [RATIO_W-1:0] ratio, hsp_fac, presc_q;
  logic               last;

  always_comb begin
    hsp_fac = (hsp_i == '0) ? RATIO_W'(1) : RATIO_W'({hsp_i, 1'b0});
    ratio   = hsp_fac << ckd_i;
    last    = presc_q >= (ratio - RATIO_W'(1));
    tick_o  = en_i && last;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   presc_q <= '0;
    else if (en_i) presc_q <= last ? '0 : presc_q + RATIO_W'(1);
  end

  // R10
  presc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(presc_q));
  // R10
  tick_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> en_i);
endmodule

// File: rtl/pwm_tb_period.sv
module pwm_tb_period #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             imm_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             zero_evt_i,
  output logic [CNT_W-1:0] act_o
);
  logic [CNT_W-1:0] shd_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= '0;
      act_q <= '0;
    end else begin
      if (we_i) shd_q <= wdata_i;
      if (we_i && imm_i)   act_q <= wdata_i;
      else if (zero_evt_i) act_q <= shd_q;
    end
  end

  assign act_o = act_q;

  // R9
  imm_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && imm_i |=> act_q == $past(wdata_i));
  // R8
  shd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && imm_i) && !zero_evt_i |=> $stable(act_q));
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  cnt_mode_e        mode_i,
  input  logic [CNT_W-1:0] prd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o,
  output logic             prd_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             down_q, down_d;
  logic             at_zero, at_prd;

  assign at_zero = cnt_q == '0;
  assign at_prd  = cnt_q == prd_i;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    if (tick_i) begin
      unique case (mode_i)
        CM_UP:   cnt_d = (cnt_q >= prd_i) ? '0 : cnt_q + CNT_W'(1);
        CM_DOWN: cnt_d = at_zero ? prd_i : cnt_q - CNT_W'(1);
        CM_UPDN: begin
          if (!down_q) begin
            if (cnt_q >= prd_i) begin
              down_d = 1'b1;
              cnt_d  = at_zero ? '0 : cnt_q - CNT_W'(1);
            end else cnt_d = cnt_q + CNT_W'(1);
          end else begin
            if (at_zero) begin
              down_d = 1'b0;
              cnt_d  = (prd_i == '0) ? '0 : CNT_W'(1);
            end else cnt_d = cnt_q - CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = tick_i && at_zero && (mode_i != CM_FRZ);
  assign prd_o  = tick_i && at_prd  && (mode_i != CM_FRZ);

  // R3
  up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && mode_i == CM_UP && cnt_q < prd_i |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R4
  down_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && mode_i == CM_DOWN && cnt_q == '0 |=> cnt_q == $past(prd_i));
  // R5
  updn_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && mode_i == CM_UPDN && cnt_q == '0 && prd_i != '0 |=> cnt_q == CNT_W'(1));
  // R6
  frz_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == CM_FRZ |=> $stable(cnt_q) && $stable(down_q));
  // R7
  zero_leave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o && mode_i == CM_UP && prd_i != '0 |=> cnt_q == CNT_W'(1));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  logic             ctrl_we_i,
  input  logic [1:0]       ctrl_mode_i,
  input  logic             ctrl_prd_imm_i,
  input  logic [DIV_W-1:0] ctrl_hsp_i,
  input  logic [DIV_W-1:0] ctrl_ckd_i,
  input  logic             prd_we_i,
  input  logic [CNT_W-1:0] prd_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] act_prd_o,
  output logic             zero_o,
  output logic             prd_match_o
);
  cnt_mode_e        mode_q;
  logic             imm_q;
  logic [DIV_W-1:0] hsp_q, ckd_q;
  logic             tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= CM_UP;
      imm_q  <= 1'b0;
      hsp_q  <= '0;
      ckd_q  <= '0;
    end else if (ctrl_we_i) begin
      mode_q <= cnt_mode_e'(ctrl_mode_i);
      imm_q  <= ctrl_prd_imm_i;
      hsp_q  <= ctrl_hsp_i;
      ckd_q  <= ctrl_ckd_i;
    end
  end

  pwm_tb_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk_i, .rst_ni, .en_i(tick_en_i), .hsp_i(hsp_q), .ckd_i(ckd_q), .tick_o(tick)
  );

  pwm_tb_period #(.CNT_W(CNT_W)) u_prd (
    .clk_i, .rst_ni, .we_i(prd_we_i), .imm_i(imm_q), .wdata_i(prd_wdata_i),
    .zero_evt_i(zero_o), .act_o(act_prd_o)
  );

  pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .mode_i(mode_q), .prd_i(act_prd_o),
    .cnt_o, .zero_o, .prd_o(prd_match_o)
  );

  // R10
  no_evt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_en_i |-> !zero_o && !prd_match_o);
endmodule

// File: tb/pwm_timebase_bench.sv
module pwm_timebase_bench;
  logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic        cwe = 1'b0, imm = 1'b0, pwe = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [2:0]  hsp = 3'd0, ckd = 3'd0;
  logic [15:0] pwd = 16'd0;
  logic [15:0] cnt, act;
  logic        zero, pm;
  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  pwm_timebase u_pwm_timebase (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(en), .ctrl_we_i(cwe), .ctrl_mode_i(mode),
    .ctrl_prd_imm_i(imm), .ctrl_hsp_i(hsp), .ctrl_ckd_i(ckd), .prd_we_i(pwe),
    .prd_wdata_i(pwd), .cnt_o(cnt), .act_prd_o(act), .zero_o(zero), .prd_match_o(pm)
  );

  // reference model state
  int m_cnt, m_act, m_shd, m_pc, m_mode, m_ckd, m_hsp;
  bit m_down, m_imm;

  function automatic int ratio_of(int h, int c);
    return (h == 0 ? 1 : 2 * h) << c;
  endfunction
  function automatic bit m_tick();
    return en && (m_pc >= ratio_of(m_hsp, m_ckd) - 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_act = 0; m_shd = 0; m_pc = 0; m_mode = 0; m_ckd = 0; m_hsp = 0;
      m_down = 0; m_imm = 0;
    end else begin
      bit t, ze;
      int nc, na;
      t  = m_tick();
      ze = t && m_cnt == 0 && m_mode != 3;
      nc = m_cnt;
      if (t) begin
        case (m_mode)
          0: nc = (m_cnt >= m_act) ? 0 : m_cnt + 1;
          1: nc = (m_cnt == 0) ? m_act : m_cnt - 1;
          2: if (!m_down) begin
               if (m_cnt >= m_act) begin m_down = 1; nc = (m_cnt == 0) ? 0 : m_cnt - 1; end
               else nc = m_cnt + 1;
             end else begin
               if (m_cnt == 0) begin m_down = 0; nc = (m_act == 0) ? 0 : 1; end
               else nc = m_cnt - 1;
             end
          default: ;
        endcase
      end
      na = m_act;
      if (pwe && m_imm) na = pwd;
      else if (ze) na = m_shd;
      if (pwe) m_shd = pwd;
      if (en) m_pc = (m_pc >= ratio_of(m_hsp, m_ckd) - 1) ? 0 : m_pc + 1;
      m_cnt = nc; m_act = na;
      if (cwe) begin m_mode = mode; m_imm = imm; m_hsp = hsp; m_ckd = ckd; end
    end
  end

  task automatic check(string req, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, actual, expected, $time);
    end
  endtask

  // per-cycle comparison, 2 ns after the falling edge
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      bit t;
      t = m_tick();
      check(cur_req, "cnt_o", cnt, m_cnt);
      check(cur_req, "act_prd_o", act, m_act);
      check("R7", "zero_o", zero, t && m_cnt == 0 && m_mode != 3);
      check("R7", "prd_match_o", pm, t && m_cnt == m_act && m_mode != 3);
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr_ctrl(int md, bit im, int h, int c);
    @(negedge clk);
    cwe = 1; mode = md[1:0]; imm = im; hsp = h[2:0]; ckd = c[2:0];
    @(negedge clk);
    cwe = 0;
  endtask
  task automatic wr_prd(int v);
    @(negedge clk);
    pwe = 1; pwd = v[15:0];
    @(negedge clk);
    pwe = 0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #35;
    // R1: reset state, before any edge following release
    check("R1", "cnt_o", cnt, 0);
    check("R1", "act_prd_o", act, 0);
    check("R1", "zero_o", zero, 0);
    check("R1", "prd_match_o", pm, 0);
    rst_n = 1;
    run(3);
    check("R1", "cnt idle", cnt, 0);
    en = 1;
    run(5);  // default: up, ratio 1, P=0 -> both strobes each tick

    // R9: immediate period load
    cur_req = "R9";
    wr_ctrl(0, 1, 0, 0);
    @(negedge clk); pwe = 1; pwd = 16'd5;
    @(negedge clk); pwe = 0; #2;
    check("R9", "act after imm write", act, 5);

    // R3 R4 R5: modes over several periods at ratio 1 and 2
    for (int md = 0; md < 3; md++) begin
      cur_req = (md == 0) ? "R3" : (md == 1) ? "R4" : "R5";
      for (int h = 0; h < 2; h++)
        for (int p = 0; p < 6; p++) begin
          wr_ctrl(md, 1, h, 0);
          wr_prd(p);
          run(4 * (p + 1) * (h + 1) + 3);
        end
    end

    // R2: every prescaler setting, up mode, P=1
    cur_req = "R2";
    wr_prd(1);
    for (int c = 0; c < 8; c++)
      for (int h = 0; h < 8; h++) begin
        wr_ctrl(0, 1, h, c);
        run(3 * ratio_of(h, c));
      end

    // R8: shadow load waits for the zero event
    cur_req = "R8";
    wr_ctrl(0, 1, 0, 0);
    wr_prd(9);
    run(12);
    wr_ctrl(0, 0, 0, 0);
    run(3);
    @(negedge clk); pwe = 1; pwd = 16'd3;
    @(negedge clk); pwe = 0; #2;
    check("R8", "act held after shadow write", act, 9);
    run(30);
    check("R8", "act after zero event", act, 3);
    wr_ctrl(1, 0, 1, 0);
    wr_prd(7);
    run(40);
    wr_ctrl(2, 0, 0, 1);
    wr_prd(4);
    run(60);

    // R6: freeze mid up-down, then resume
    cur_req = "R6";
    wr_ctrl(2, 1, 0, 0);
    wr_prd(10);
    run(14);
    wr_ctrl(3, 1, 0, 0);
    run(25);
    cur_req = "R5";
    wr_ctrl(2, 1, 0, 0);
    run(30);

    // R10: tick enable low holds everything
    cur_req = "R10";
    wr_ctrl(0, 1, 2, 1);
    run(9);
    @(negedge clk); en = 0;
    run(40);
    @(negedge clk); en = 1;
    run(40);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule